// File: doc/BRIEF.md
# SHA-2 Streaming Message Preprocessor

This block sits in front of a SHA-2 digest engine. It accepts a message length in bytes on a command stream and then the message itself as a byte stream. From these it builds complete 16-word blocks: it appends a single marker bit, then zero fill, and finally the message bit length as a big-endian field. The words of those blocks leave on an output stream. A parameter selects 32-bit words, for the 224/256-bit digests, or 64-bit words, for the 384/512-bit family.

Before the first word of a message, a separate stream carries the number of blocks that the message occupies. The digest stage can therefore run as an independent process fed through FIFOs, and it knows in advance how many compressions to perform. All four streams use a valid/ready handshake. A transfer happens on a clock edge where both valid and ready are high.

Internally a four-state machine sequences each message. ST_IDLE waits for a length and moves to ST_COUNT on acceptance. ST_COUNT offers the block count and moves to ST_FILL once it is taken. ST_FILL assembles one word, one byte per step, and moves to ST_SEND after the last byte of the word. ST_SEND offers the word. When the word is taken, ST_SEND returns to ST_FILL if more words remain, or to ST_IDLE after the final word of the message.

Top module: `sha2_msg_prep`

## Requirements
- R1: After reset, only `len_ready` is high among the outputs. A length accepted at an edge produces, from the next cycle on, `cnt_valid` high with `cnt_data` = ceil((L + 1 + F) / B). Here L is the length in bytes, F the length-field size in bytes (8 for 32-bit words, 16 for 64-bit words) and B the block size in bytes (64 or 128).
- R2: The block count of a message is transferred before any word of that message is offered.
- R3: Each message yields exactly 16 × `cnt_data` words. `w_valid` then stays low until a new length is accepted.
- R4: Message bytes are packed most-significant byte first. Byte i of the padded message sits in word i / (WORD_W/8), at bit position WORD_W-8-8·(i mod (WORD_W/8)).
- R5: Padded byte L is 0x80. Every byte after it and before the length field is 0x00.
- R6: The last F bytes of the padded message hold 8·L as a big-endian unsigned number.
- R7: A zero-length message gives one block. Its first byte is 0x80, its length field is zero and every other byte is zero.
- R8: A second block is added when the marker and the length field do not fit after the data. In 32-bit mode L = 55 gives 1 block, L = 56 gives 2, L = 119 gives 2 and L = 120 gives 3.
- R9: While `cnt_valid` is high and `cnt_ready` low, `cnt_valid` and `cnt_data` hold. While `w_valid` is high and `w_ready` low, `w_valid` and `w_data` hold.
- R10: Exactly L bytes are consumed from the byte stream per message. `in_valid` held high beyond the message has no effect.
- R11: `len_ready` is low from the acceptance of a length until the final word of that message has been transferred, and high again from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| len_valid | input | 1 | Message length offered |
| len_ready | output | 1 | Length can be accepted (block idle) |
| len_bytes | input | MSG_LEN_W | Message length in bytes |
| in_valid | input | 1 | Message byte offered |
| in_ready | output | 1 | Message byte can be taken |
| in_data | input | 8 | Message byte |
| cnt_valid | output | 1 | Block count offered |
| cnt_ready | input | 1 | Block count can be taken |
| cnt_data | output | MSG_LEN_W+1 | Number of blocks in the message |
| w_valid | output | 1 | Message word offered |
| w_ready | input | 1 | Message word can be taken |
| w_data | output | WORD_W | Message word, first byte in the top bits |

## Verification
Message lengths are chosen around the block edges: 0, 55, 56, 64, 119, 120 and 200 bytes. These lengths separate an off-by-one in the fit test of the marker and length field (55 against 56, 119 against 120) from an error in the division. They also separate a marker placed on a word boundary from one placed inside a word. Each length is run with a distinct byte pattern so that misordered or repeated bytes show up. Free-flowing runs hold `in_valid` high past the message end, which exposes over-consumption. Runs with irregular ready and valid gaps on every stream expose a lost or changed word while the output is stalled, and a count that arrives out of order.

// File: rtl/sha2_prep_pkg.sv
package sha2_prep_pkg;

    // Message sequencing states
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COUNT,
        ST_FILL,
        ST_SEND
    } prep_state_t;

    // Origin of the next byte of the padded message
    typedef enum logic [1:0] {
        SRC_DATA,
        SRC_MARK,
        SRC_ZERO,
        SRC_LEN
    } byte_src_t;

endpackage

// File: rtl/sha2_prep_blkcalc.sv
module sha2_prep_blkcalc #(
    parameter int WORD_W    = 32,
    parameter int MSG_LEN_W = 32
) (
    input  logic [MSG_LEN_W-1:0] len_bytes,
    output logic [MSG_LEN_W:0]   nblk,
    output logic [MSG_LEN_W:0]   tot_bytes
);
    localparam int BPW         = WORD_W / 8;
    localparam int BLOCK_BYTES = 16 * BPW;
    localparam int BB_LG       = $clog2(BLOCK_BYTES);
    localparam int FIELD_BYTES = 2 * BPW;
    localparam int TOT_W       = MSG_LEN_W + 1;

    logic [TOT_W-1:0] padded_ceil;

    always_comb begin
        // data + marker + length field, rounded up to a whole block
        padded_ceil = TOT_W'(len_bytes) + TOT_W'(FIELD_BYTES + BLOCK_BYTES);
        nblk        = padded_ceil >> BB_LG;
        tot_bytes   = nblk << BB_LG;
    end

endmodule

// File: rtl/sha2_prep_bytesrc.sv
module sha2_prep_bytesrc
    import sha2_prep_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int MSG_LEN_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [MSG_LEN_W-1:0] len_new,
    input  logic                 advance,
    input  logic [MSG_LEN_W:0]   gidx,
    input  logic [MSG_LEN_W-1:0] msg_len,
    input  logic [MSG_LEN_W:0]   field_start,
    input  logic [7:0]           in_data,
    output byte_src_t            kind,
    output logic [7:0]           byte_out
);
    localparam int FIELD_W = 2 * WORD_W;

    logic [FIELD_W-1:0] field_sh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_sh <= '0;
        end else if (load) begin
            field_sh <= FIELD_W'(len_new) << 3;
        end else if (advance && kind == SRC_LEN) begin
            field_sh <= field_sh << 8;
        end
    end

    always_comb begin
        if (gidx < {1'b0, msg_len})       kind = SRC_DATA;
        else if (gidx == {1'b0, msg_len}) kind = SRC_MARK;
        else if (gidx >= field_start)     kind = SRC_LEN;
        else                              kind = SRC_ZERO;
    end

    always_comb begin
        unique case (kind)
            SRC_DATA: byte_out = in_data;
            SRC_MARK: byte_out = 8'h80;
            SRC_LEN:  byte_out = field_sh[FIELD_W-1 -: 8];
            default:  byte_out = 8'h00;
        endcase
    end

endmodule

// File: rtl/sha2_prep_packer.sv
module sha2_prep_packer #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic [7:0]        byte_in,
    output logic [WORD_W-1:0] word_out
);
    localparam int BPW = WORD_W / 8;

    logic [7:0] lane_q [BPW];

    // byte lanes form a chain: lane 0 is the newest byte, lane BPW-1 the oldest
    for (genvar g = 0; g < BPW; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q[g] <= 8'h00;
            end else if (shift_en) begin
                if (g == 0) lane_q[g] <= byte_in;
                else        lane_q[g] <= lane_q[(g == 0) ? 0 : g-1];
            end
        end
        assign word_out[8*g +: 8] = lane_q[g];
    end

endmodule

// File: rtl/sha2_msg_prep.sv
module sha2_msg_prep
    import sha2_prep_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int MSG_LEN_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 len_valid,
    output logic                 len_ready,
    input  logic [MSG_LEN_W-1:0] len_bytes,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [7:0]           in_data,
    output logic                 cnt_valid,
    input  logic                 cnt_ready,
    output logic [MSG_LEN_W:0]   cnt_data,
    output logic                 w_valid,
    input  logic                 w_ready,
    output logic [WORD_W-1:0]    w_data
);
    localparam int BPW         = WORD_W / 8;
    localparam int BPW_LG      = $clog2(BPW);
    localparam int BLOCK_BYTES = 16 * BPW;
    localparam int BB_LG       = $clog2(BLOCK_BYTES);
    localparam int FIELD_BYTES = 2 * BPW;
    localparam int TOT_W       = MSG_LEN_W + 1;

    prep_state_t          state_q, state_d;
    logic [MSG_LEN_W-1:0] msg_len_q;
    logic [TOT_W-1:0]     tot_q, nblk_q, gidx_q;
    logic [TOT_W-1:0]     calc_nblk, calc_tot, field_start;
    byte_src_t            kind;
    logic [7:0]           next_byte;
    logic                 accept, step, word_end, msg_end;

    sha2_prep_blkcalc #(.WORD_W(WORD_W), .MSG_LEN_W(MSG_LEN_W)) u_calc (
        .len_bytes (len_bytes),
        .nblk      (calc_nblk),
        .tot_bytes (calc_tot)
    );

    assign field_start = tot_q - TOT_W'(FIELD_BYTES);

    sha2_prep_bytesrc #(.WORD_W(WORD_W), .MSG_LEN_W(MSG_LEN_W)) u_src (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (accept),
        .len_new     (len_bytes),
        .advance     (step),
        .gidx        (gidx_q),
        .msg_len     (msg_len_q),
        .field_start (field_start),
        .in_data     (in_data),
        .kind        (kind),
        .byte_out    (next_byte)
    );

    sha2_prep_packer #(.WORD_W(WORD_W)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (step),
        .byte_in  (next_byte),
        .word_out (w_data)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // handshake decode and outputs
    always_comb begin
        len_ready = (state_q == ST_IDLE);
        cnt_valid = (state_q == ST_COUNT);
        w_valid   = (state_q == ST_SEND);
        in_ready  = (state_q == ST_FILL) && (kind == SRC_DATA);
        cnt_data  = nblk_q;
        accept    = len_ready && len_valid;
        step      = (state_q == ST_FILL) && ((kind != SRC_DATA) || in_valid);
        word_end  = step && (gidx_q[BPW_LG-1:0] == BPW_LG'(BPW-1));
        msg_end   = (gidx_q == tot_q);
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (len_valid) state_d = ST_COUNT;
            ST_COUNT: if (cnt_ready) state_d = ST_FILL;
            ST_FILL:  if (word_end)  state_d = ST_SEND;
            ST_SEND:  if (w_ready)   state_d = msg_end ? ST_IDLE : ST_FILL;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // message bookkeeping registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_len_q <= '0;
            tot_q     <= '0;
            nblk_q    <= '0;
            gidx_q    <= '0;
        end else if (accept) begin
            msg_len_q <= len_bytes;
            tot_q     <= calc_tot;
            nblk_q    <= calc_nblk;
            gidx_q    <= '0;
        end else if (step) begin
            gidx_q    <= gidx_q + TOT_W'(1);
        end
    end

    // R1
    count_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (len_valid && len_ready) |=> cnt_valid &&
        (cnt_data == TOT_W'((TOT_W'($past(len_bytes)) + TOT_W'(FIELD_BYTES + BLOCK_BYTES)) >> BB_LG)));

    // R2
    count_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (len_valid && len_ready) |=> !w_valid);

    // R3
    word_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid |-> (gidx_q[BPW_LG-1:0] == '0) && (gidx_q <= tot_q));

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_valid && !cnt_ready) |=> cnt_valid && $stable(cnt_data));

    // R9
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && !w_ready) |=> w_valid && $stable(w_data));

    // R11
    idle_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && w_ready && msg_end) |=> len_ready && !w_valid);

endmodule

// File: tb/sim_sha2_msg_prep.sv
`timescale 1ns/100ps
module sim_sha2_msg_prep;

    localparam int WORD_W = 32;
    localparam int MLW    = 32;
    localparam int BPW    = WORD_W / 8;
    localparam int BB     = 16 * BPW;
    localparam int FB     = 2 * BPW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              len_valid = 1'b0;
    logic              len_ready;
    logic [MLW-1:0]    len_bytes = '0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [7:0]        in_data = 8'h00;
    logic              cnt_valid;
    logic              cnt_ready = 1'b0;
    logic [MLW:0]      cnt_data;
    logic              w_valid;
    logic              w_ready = 1'b0;
    logic [WORD_W-1:0] w_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sha2_msg_prep #(.WORD_W(WORD_W), .MSG_LEN_W(MLW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .len_valid(len_valid), .len_ready(len_ready), .len_bytes(len_bytes),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .cnt_valid(cnt_valid), .cnt_ready(cnt_ready), .cnt_data(cnt_data),
        .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * 7 + seed * 13 + (i >> 3)) & 255);
    endfunction

    function automatic logic [7:0] exp_byte(input int i, input int len, input int seed, input int tot);
        longint bitlen = longint'(len) * 8;
        int k = tot - 1 - i;
        if (i < len)  return pat(i, seed);
        if (i == len) return 8'h80;
        if (k < FB)   return 8'((bitlen >> (8 * k)) & 255);
        return 8'h00;
    endfunction

    task automatic run_msg(input int len, input int seed, input bit bp, input string cnt_tag);
        int nexp = (len + FB + BB) / BB;
        int tot = nexp * BB;
        int fed = 0, words = 0, cyc = 0;
        bit got_cnt = 0, early = 0, busy_bad = 0, hold_bad = 0, prev_stall = 0;
        longint cval = 0;
        logic [WORD_W-1:0] prev_data = '0;
        @(negedge clk);
        len_bytes = MLW'(len);
        len_valid = 1'b1;
        #1;
        check(len_ready == 1'b1, "R11", longint'(len_ready), 1);
        @(negedge clk);
        len_valid = 1'b0;
        while (words < nexp * 16 && cyc < 20000) begin
            if (cyc > 0) @(negedge clk);
            in_valid  = bp ? (cyc % 3 != 2) : 1'b1;
            in_data   = pat(fed, seed);
            w_ready   = bp ? (cyc % 2 == 0) : 1'b1;
            cnt_ready = bp ? (cyc % 4 == 3) : 1'b1;
            #1;
            if (prev_stall && (!w_valid || w_data != prev_data)) hold_bad = 1;
            if (in_valid && in_ready) fed++;
            if (cnt_valid && cnt_ready) begin
                got_cnt = 1;
                cval = longint'(cnt_data);
                if (words > 0) early = 1;
            end
            if (w_valid && !got_cnt) early = 1;
            if (len_ready) busy_bad = 1;
            if (w_valid && w_ready) begin
                logic [WORD_W-1:0] ew = '0;
                string tag;
                int b0 = words * BPW;
                for (int b = 0; b < BPW; b++) ew = {ew[WORD_W-9:0], exp_byte(b0 + b, len, seed, tot)};
                if (cnt_tag == "R7")               tag = "R7";
                else if (b0 + BPW > tot - FB)      tag = "R6";
                else if (len >= b0 && len < b0 + BPW) tag = "R5";
                else if (b0 > len)                 tag = "R5";
                else                               tag = "R4";
                check(w_data == ew, tag, longint'(w_data), longint'(ew));
                words++;
            end
            prev_stall = w_valid && !w_ready;
            prev_data  = w_data;
            cyc++;
        end
        @(negedge clk);
        w_ready = 1'b1; cnt_ready = 1'b1; in_valid = 1'b0;
        repeat (3) begin
            @(negedge clk);
            #1;
            check(!w_valid && !cnt_valid, "R3", longint'(w_valid), 0);
            check(len_ready == 1'b1, "R11", longint'(len_ready), 1);
        end
        check(cval == longint'(nexp), cnt_tag, cval, longint'(nexp));
        check(words == nexp * 16, "R3", words, nexp * 16);
        check(fed == len, "R10", fed, len);
        check(!early, "R2", early, 0);
        check(!busy_bad, "R11", busy_bad, 0);
        if (bp) check(!hold_bad, "R9", hold_bad, 0);
    endtask

    task automatic reset_test();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        check(len_ready == 1'b1, "R1", longint'(len_ready), 1);
        check(!cnt_valid && !w_valid && !in_ready, "R1",
              longint'({cnt_valid, w_valid, in_ready}), 0);
        rst_n = 1'b1;
    endtask

    task automatic count_hold_test();
        // R9: count stays put while the consumer stalls
        logic [MLW:0] first;
        bit ok = 1;
        @(negedge clk);
        len_bytes = 32'd10; len_valid = 1'b1; cnt_ready = 1'b0; w_ready = 1'b1;
        @(negedge clk);
        len_valid = 1'b0;
        #1;
        first = cnt_data;
        check(cnt_valid == 1'b1, "R1", longint'(cnt_valid), 1);
        repeat (5) begin
            @(negedge clk); #1;
            if (!cnt_valid || cnt_data != first) ok = 0;
        end
        check(ok, "R9", longint'(cnt_data), longint'(first));
        @(negedge clk);
        cnt_ready = 1'b1; in_valid = 1'b1;
        while (!len_ready) @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        reset_test();
        run_msg(0,   1, 0, "R7");
        run_msg(55,  2, 0, "R8");
        run_msg(56,  3, 0, "R8");
        run_msg(64,  4, 1, "R1");
        run_msg(119, 5, 0, "R8");
        run_msg(120, 6, 1, "R8");
        run_msg(200, 7, 1, "R1");
        run_msg(3,   8, 1, "R1");
        count_hold_test();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule